// File: doc/BRIEF.md
# Compare-Terminated Byte String Loader

This block moves a run of bytes from a byte-addressed memory into a bank of 32-bit registers. A start command gives a starting memory address, the register that receives the first byte, a byte count, a compare byte, and the numbers of two registers that must not be overwritten: the base register and the index register. The block fetches one byte per memory handshake and fills each register from its most significant byte down. After the last byte lane of a register is filled, it moves to the next register number, wrapping from 31 back to 0.

The run ends when the byte count is used up or when a fetched byte equals the compare byte. A matching byte is still written, subject to the protection rule, and then the run stops. On completion the block raises a one-cycle done pulse and presents the number of bytes handled. Register writes leave the bank as byte-enabled writes, so only the lane being loaded changes and the other lanes keep their contents. When a register is protected, its write is dropped but the byte still uses its lane and the register sequence moves on as usual.

Top module: `cmp_string_loader`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `reg_we` are all 0.
- R2: A start with a byte count of 0 performs no memory read and gives `done` with `result` = 0 on the cycle after the start.
- R3: Each byte is fetched by one `mem_req`/`mem_ack` handshake. `mem_addr` holds steady while waiting, the k-th fetch (counting from 0) reads start address + k, and the address wraps modulo 2^ADDR_W.
- R4: Byte k of a register goes into lane k mod 4. Lane 0 is bits 31:24 (`reg_be` = 4'b1000) and lane 3 is bits 7:0 (`reg_be` = 4'b0001). Exactly one enable bit is set, and `reg_wdata` carries the byte in that lane with zeros elsewhere.
- R5: After lane 3, loading moves to register number (current + 1) mod 32, starting again at lane 0.
- R6: No write is issued when the current register equals the index register, or equals the base register while the base register is nonzero. A base register of 0 protects nothing. The lane and register sequence advance exactly as if the write had happened.
- R7: When a fetched byte equals the compare byte, that byte is written (subject to R6) and no further fetch is made. `result` is its 0-based position.
- R8: When no byte matches, exactly `byte_count` bytes are fetched and `result` equals `byte_count`.
- R9: `done` is a single-cycle pulse. When it is high, `busy` and `mem_req` are low, and the final register write appears in the same cycle.
- R10: A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command strobe |
| start_addr | input | ADDR_W | Address of the first byte |
| start_reg | input | 5 | Register that receives the first byte |
| base_reg | input | 5 | Base register number (protected when nonzero) |
| index_reg | input | 5 | Index register number (always protected) |
| byte_count | input | CNT_W | Number of bytes to load |
| cmp_byte | input | 8 | Terminating compare byte |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_ack | input | 1 | Read acknowledge; data valid |
| mem_rdata | input | 8 | Read byte |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 5 | Register number written |
| reg_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| reg_wdata | output | 32 | Write data, byte placed in its lane |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | CNT_W | Bytes processed (match position or count) |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high, and that `mem_rdata` is valid in that same cycle. The bench's memory responder enforces this by deriving the acknowledge from the request it sees, with a pseudo-random stall pattern. The protection check also assumes that the base and index numbers seen with an accepted start are the ones in force for the whole run. The bench keeps that premise even in the R10 case: the start it applies while busy carries other register numbers and a count of 0, and the design must ignore that start entirely.

// File: rtl/csl_pkg.sv
package csl_pkg;
  typedef enum logic [0:0] {
    CSL_IDLE  = 1'b0,
    CSL_FETCH = 1'b1
  } csl_state_t;
endpackage

// File: rtl/csl_cursor.sv
// Tracks destination register and byte lane, and flags protected registers.
module csl_cursor #(
  parameter int REG_AW = 5,
  parameter int BYTES  = 4,
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [REG_AW-1:0] first_reg,
  input  logic [REG_AW-1:0] base_in,
  input  logic [REG_AW-1:0] index_in,
  output logic [REG_AW-1:0] cur_reg,
  output logic [LANE_W-1:0] cur_lane,
  output logic              guarded
);
  logic [REG_AW-1:0] base_q, index_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_reg  <= '0;
      cur_lane <= '0;
      base_q   <= '0;
      index_q  <= '0;
    end else if (load) begin
      cur_reg  <= first_reg;
      cur_lane <= '0;
      base_q   <= base_in;
      index_q  <= index_in;
    end else if (step) begin
      if (cur_lane == LANE_W'(BYTES - 1)) begin
        cur_lane <= '0;
        cur_reg  <= cur_reg + 1'b1;
      end else begin
        cur_lane <= cur_lane + 1'b1;
      end
    end
  end

  assign guarded = (cur_reg == index_q) || ((base_q != '0) && (cur_reg == base_q));
endmodule

// File: rtl/csl_fetch.sv
// Byte read port: holds request and address until acknowledged.
module csl_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              step,
  input  logic              stop,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (load) begin
      mem_req  <= load_go;
      mem_addr <= addr_in;
    end else if (step) begin
      mem_req  <= !stop;
      mem_addr <= mem_addr + 1'b1;
    end
  end
endmodule

// File: rtl/csl_lane_write.sv
// Registers a byte-enabled write with the byte steered into its lane.
module csl_lane_write #(
  parameter int REG_AW = 5,
  parameter int BYTES  = 4,
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int DATA_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              guarded,
  input  logic [7:0]        byte_in,
  input  logic [LANE_W-1:0] lane,
  input  logic [REG_AW-1:0] dest,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_waddr,
  output logic [BYTES-1:0]  reg_be,
  output logic [DATA_W-1:0] reg_wdata
);
  logic [BYTES-1:0]  be_d;
  logic [DATA_W-1:0] data_d;

  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    assign be_d[BYTES-1-l] = (lane == LANE_W'(l));
    assign data_d[(BYTES-1-l)*8 +: 8] = (lane == LANE_W'(l)) ? byte_in : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_be    <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= fire && !guarded;
      if (fire) begin
        reg_waddr <= dest;
        reg_be    <= be_d;
        reg_wdata <= data_d;
      end
    end
  end
endmodule

// File: rtl/cmp_string_loader.sv
module cmp_string_loader #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [4:0]        start_reg,
  input  logic [4:0]        base_reg,
  input  logic [4:0]        index_reg,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        cmp_byte,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              reg_we,
  output logic [4:0]        reg_waddr,
  output logic [3:0]        reg_be,
  output logic [31:0]       reg_wdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  result
);
  import csl_pkg::*;

  localparam int REG_AW = 5;
  localparam int BYTES  = 4;
  localparam int LANE_W = $clog2(BYTES);

  csl_state_t        state;
  logic [CNT_W-1:0]  cnt_q, pos_q;
  logic [7:0]        cmp_q;
  logic              accept, fire, hit, last, finish, guarded;
  logic [REG_AW-1:0] cur_reg;
  logic [LANE_W-1:0] cur_lane;

  assign accept = (state == CSL_IDLE) && start;
  assign fire   = (state == CSL_FETCH) && mem_ack;
  assign hit    = (mem_rdata == cmp_q);
  assign last   = (CNT_W'(pos_q + 1'b1) == cnt_q);
  assign finish = hit || last;
  assign busy   = (state == CSL_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CSL_IDLE;
      cnt_q  <= '0;
      pos_q  <= '0;
      cmp_q  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        CSL_IDLE: if (start) begin
          cnt_q <= byte_count;
          cmp_q <= cmp_byte;
          pos_q <= '0;
          if (byte_count == '0) begin
            done   <= 1'b1;
            result <= '0;
          end else begin
            state <= CSL_FETCH;
          end
        end
        CSL_FETCH: if (mem_ack) begin
          pos_q <= pos_q + 1'b1;
          if (finish) begin
            state  <= CSL_IDLE;
            done   <= 1'b1;
            result <= hit ? pos_q : cnt_q;
          end
        end
        default: state <= CSL_IDLE;
      endcase
    end
  end

  csl_cursor #(.REG_AW(REG_AW), .BYTES(BYTES)) u_cursor (
    .clk(clk), .rst(rst), .load(accept), .step(fire),
    .first_reg(start_reg), .base_in(base_reg), .index_in(index_reg),
    .cur_reg(cur_reg), .cur_lane(cur_lane), .guarded(guarded)
  );

  csl_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .load(accept), .load_go(byte_count != '0),
    .addr_in(start_addr), .step(fire), .stop(finish),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

  csl_lane_write #(.REG_AW(REG_AW), .BYTES(BYTES)) u_write (
    .clk(clk), .rst(rst), .fire(fire), .guarded(guarded),
    .byte_in(mem_rdata), .lane(cur_lane), .dest(cur_reg),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_be(reg_be), .reg_wdata(reg_wdata)
  );
endmodule

// File: rtl/csl_checker.sv
module csl_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [4:0]        base_reg,
  input logic [4:0]        index_reg,
  input logic [CNT_W-1:0]  byte_count,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              reg_we,
  input logic [4:0]        reg_waddr,
  input logic [3:0]        reg_be,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  result
);
  logic [4:0] base_q, index_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      index_q <= '0;
    end else if (start && !busy) begin
      base_q  <= base_reg;
      index_q <= index_reg;
    end
  end

  a_r1_req_in_run: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  a_r2_zero_count: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && byte_count == '0) |=> (done && result == '0 && !mem_req));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r4_one_lane: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> ($countones(reg_be) == 1));

  a_r6_protect: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_waddr != index_q && (base_q == '0 || reg_waddr != base_q)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_idle_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));
endmodule

bind cmp_string_loader csl_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .base_reg(base_reg), .index_reg(index_reg),
  .byte_count(byte_count), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_be(reg_be), .busy(busy),
  .done(done), .result(result)
);

// File: tb/cmp_string_loader_bench.sv
module cmp_string_loader_bench;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [4:0]        start_reg = '0, base_reg = '0, index_reg = '0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [7:0]        cmp_byte = '0;
  logic              mem_req, mem_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata = '0;
  logic              reg_we, busy, done;
  logic [4:0]        reg_waddr;
  logic [3:0]        reg_be;
  logic [31:0]       reg_wdata;
  logic [CNT_W-1:0]  result;

  cmp_string_loader #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cmp_string_loader (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .start_reg(start_reg),
    .base_reg(base_reg), .index_reg(index_reg), .byte_count(byte_count), .cmp_byte(cmp_byte),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .busy(busy), .done(done), .result(result)
  );

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] rf [32];
  logic [31:0] m_rf [32];
  logic [31:0] exp_addr [$];
  logic [40:0] exp_wr [$];
  int          exp_res = 0;
  bit          done_seen = 0, prev_done = 0;
  logic [7:0]  lfsr = 8'h5A;

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ a[15:8] ^ {a[3:0], a[31:28]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor and memory responder, both at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      if (prev_done) chk(!done, "R9 done pulse width", done, 0);
      prev_done = done;
      if (reg_we) begin
        if (exp_wr.size() == 0) chk(0, "R6 unexpected write", reg_waddr, 0);
        else chk({reg_waddr, reg_be, reg_wdata} == exp_wr[0], "R4/R5/R6 write",
                 {reg_waddr, reg_be, reg_wdata}, exp_wr[0]);
        if (exp_wr.size() != 0) void'(exp_wr.pop_front());
        for (int b = 0; b < 4; b++)
          if (reg_be[b]) rf[reg_waddr][b*8 +: 8] = reg_wdata[b*8 +: 8];
      end
      if (done) begin
        chk(result == CNT_W'(exp_res), "R7/R8 result", result, exp_res);
        chk(!busy && !mem_req, "R9 idle with done", {busy, mem_req}, 0);
        chk(exp_addr.size() == 0 && exp_wr.size() == 0, "R3/R7 all events seen",
            exp_addr.size() + exp_wr.size(), 0);
        done_seen = 1;
      end
      if (cycles > 100000) begin
        chk(0, "watchdog", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ack = !rst && mem_req && (lfsr[1:0] != 2'b00);
    mem_rdata = mem_ack ? mbyte(mem_addr) : 8'hXX;
    if (mem_ack) begin
      if (exp_addr.size() == 0) chk(0, "R3 unexpected read", mem_addr, 0);
      else begin
        chk(mem_addr == exp_addr[0], "R3 read address", mem_addr, exp_addr[0]);
        void'(exp_addr.pop_front());
      end
    end
  end

  function automatic logic [7:0] free_byte(input logic [31:0] a, input int n);
    for (int c = 0; c < 256; c++) begin
      bit used = 0;
      for (int i = 0; i < n; i++) if (mbyte(a + 32'(i)) == 8'(c)) used = 1;
      if (!used) return 8'(c);
    end
    return 8'h00;
  endfunction

  // Reference model of one run: fills expected queues and m_rf.
  task automatic plan(input logic [31:0] a, input logic [4:0] r0, input logic [4:0] b,
                      input logic [4:0] x, input int n, input logic [7:0] c);
    logic [4:0] r = r0;
    int lane = 0;
    exp_res = n;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = mbyte(a + 32'(i));
      exp_addr.push_back(a + 32'(i));
      if (!(r == x || (b != 0 && r == b))) begin
        exp_wr.push_back({r, 4'b1000 >> lane, 32'(v) << (24 - 8*lane)});
        m_rf[r][(24 - 8*lane) +: 8] = v;
      end
      if (v == c) begin exp_res = i; break; end
      lane++;
      if (lane == 4) begin lane = 0; r = r + 5'd1; end
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [4:0] r0, input logic [4:0] b,
                     input logic [4:0] x, input int n, input int match_at, input bit poke);
    logic [7:0] c = (match_at < 0) ? free_byte(a, n) : mbyte(a + 32'(match_at));
    int wait_n = 0;
    @(negedge clk);
    plan(a, r0, b, x, n, c);
    done_seen = 0;
    start = 1; start_addr = a; start_reg = r0; base_reg = b; index_reg = x;
    byte_count = CNT_W'(n); cmp_byte = c;
    @(negedge clk);
    start = 0;
    if (poke) begin
      @(negedge clk);
      // R10: a second start while busy, with other numbers and a zero count
      chk(busy, "R10 busy before second start", busy, 1);
      start = 1; start_reg = 5'd9; base_reg = 5'd0; index_reg = 5'd1; byte_count = '0;
      @(negedge clk);
      start = 0;
    end
    while (!done_seen && wait_n < 2000) begin @(negedge clk); wait_n++; end
    chk(done_seen, "R9 run completes", done_seen, 1);
    for (int i = 0; i < 32; i++)
      chk(rf[i] == m_rf[i], "R4/R5/R6 register contents", rf[i], m_rf[i]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf[i] = 32'(i) * 32'h01010101 ^ 32'hA5000000;
      m_rf[i] = rf[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_req && !reg_we, "R1 reset outputs",
        {busy, done, mem_req, reg_we}, 0);
    rst = 0;
    run(32'h0000_1000, 5'd4, 5'd0, 5'd31, 0, -1, 0);       // R2 zero count
    run(32'h0000_2000, 5'd3, 5'd0, 5'd31, 4, -1, 0);       // R4 one full register, R8
    run(32'h0000_3001, 5'd4, 5'd5, 5'd6, 13, -1, 0);       // R6 base and index skipped
    run(32'h0000_4000, 5'd30, 5'd0, 5'd20, 13, -1, 0);     // R5 wrap 31 -> 0
    run(32'h0000_5000, 5'd0, 5'd0, 5'd2, 9, -1, 0);        // R6 base 0 protects nothing
    run(32'h0000_6000, 5'd8, 5'd0, 5'd31, 20, 5, 0);       // R7 match mid-run
    run(32'h0000_7003, 5'd12, 5'd0, 5'd31, 10, 0, 0);      // R7 match on first byte
    run(32'hFFFF_FFFE, 5'd16, 5'd0, 5'd31, 5, -1, 0);      // R3 address wrap
    run(32'h0001_0000, 5'd7, 5'd9, 5'd10, 127, -1, 0);     // R8 longest run, full wrap
    run(32'h0002_0000, 5'd20, 5'd0, 5'd31, 12, -1, 1);     // R10 start while busy
    run(32'h0003_0000, 5'd1, 5'd0, 5'd31, 6, 5, 0);        // R7 match on last byte
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule